// File: doc/BRIEF.md
# Ticketed Request-Grant Uniqueness Monitor

This block watches one single-bit request line and one single-bit grant line on a shared clock. It checks that each request is answered by a grant of its own within a bounded window. Every accepted request draws a ticket number. Only the oldest outstanding request, whose ticket equals the now-serving number, can be credited with a grant. A grant therefore settles exactly one request, and any requests still pending behind it keep waiting for grants of their own.

Outstanding requests sit in a small in-order queue that holds each request's ticket and age. The head of that queue is classified every cycle into one of four states:

- IDLE: no request is outstanding.
- EARLY: the head is younger than the lower window bound.
- OPEN: the head is inside the window and not yet at its last cycle.
- LAST: the head is at the upper window bound.

From these states three transitions can fire:

- pass: a grant arrives in OPEN or LAST, and the head retires.
- timeout: LAST is reached without a grant, and the head retires.
- stray: a grant arrives in IDLE or EARLY, and nobody is credited.

Each pass or timeout advances the now-serving counter by one, so a late grant can never be reused by a later request. The verdicts are registered one-cycle pulses. The ticket and now-serving counters are exposed for observation.

Top module: `rg_ticket_monitor`

## Requirements
- R1: A request sampled high on an edge while the queue is not full takes the current ticket. `ticket_o` then shows that ticket plus one, modulo 2^CNT_W, after the same edge.
- R2: A request sampled at edge E passes if, at some edge E+k with WIN_LO <= k <= WIN_HI (defaults 1 and 5), grant is high and the request is the head. `pass_o` is then high for exactly the cycle after edge E+k.
- R3: `serving_o` increases by one, modulo 2^CNT_W, at every edge that produces a pass or a timeout, and at no other edge.
- R4: One grant credits at most one request. The other outstanding requests stay queued in ticket order, and the head's ticket always equals `serving_o`.
- R5: A request that is not credited by edge E+WIN_HI gives a `timeout_o` pulse in the cycle after edge E+WIN_HI. Because at most one request retires per edge and requests are sampled on distinct edges, every request reaches the head before its window closes.
- R6: A grant on the same edge that a request is sampled (age 0) is not credited to that request.
- R7: A grant with no outstanding request, or with a head younger than WIN_LO, raises `stray_gnt_o` for the one cycle after that edge.
- R8: A request sampled while DEPTH requests are outstanding is dropped without taking a ticket. This holds even if the head retires on that same edge. `overflow_o` rises and stays high until reset.
- R9: A synchronous reset clears `ticket_o`, `serving_o`, all verdict pulses, `overflow_o` and the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request line being monitored |
| gnt_i | input | 1 | Grant line being monitored |
| pass_o | output | 1 | One-cycle pulse: head request credited with a grant |
| timeout_o | output | 1 | One-cycle pulse: head request saw no grant inside its window |
| stray_gnt_o | output | 1 | One-cycle pulse: grant that no request could take |
| overflow_o | output | 1 | Sticky flag: a request was dropped because the queue was full |
| ticket_o | output | CNT_W | Next ticket number to be issued |
| serving_o | output | CNT_W | Ticket number of the request now being served |

## Verification
The hardest situation to reach is a full queue. It only happens once DEPTH requests are outstanding at the same time, which means an unbroken run of requests with no grant to retire any of them. The stimulus reaches it in two ways. A sweep runs every 5-cycle combination of request and grant, followed by an idle drain, so the all-requests-no-grant burst occurs among the others. A dense pseudo-random run with rare grants then revisits the full queue repeatedly, together with back-to-back timeouts and late grants that land on the next ticket.

// File: rtl/rgt_pkg.sv
package rgt_pkg;

    // Classification of the oldest outstanding request.
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_EARLY = 2'd1,
        HS_OPEN  = 2'd2,
        HS_LAST  = 2'd3
    } head_state_e;

    // Outcome decided for the head on the current edge.
    typedef enum logic [1:0] {
        VD_NONE    = 2'd0,
        VD_PASS    = 2'd1,
        VD_TIMEOUT = 2'd2
    } verdict_e;

endpackage

// File: rtl/rgt_queue.sv
module rgt_queue #(
    parameter int DEPTH   = 4,
    parameter int TW      = 8,
    parameter int AW      = 3,
    parameter int AGE_MAX = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  logic [TW-1:0]                push_tkt_i,
    input  logic                         pop_i,
    output logic                         head_valid_o,
    output logic [TW-1:0]                head_tkt_o,
    output logic [AW-1:0]                head_age_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [TW-1:0]    tkt_q [DEPTH];
    logic [AW-1:0]    age_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [PW-1:0]    rd_q;
    logic [PW-1:0]    wr_q;
    logic [CW-1:0]    cnt_q;

    // Slot storage: a new entry starts at age 1 (one edge after sampling);
    // every other live entry ages by one, saturating at AGE_MAX.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tkt_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_i && (wr_q == PW'(i))) begin
                    vld_q[i] <= 1'b1;
                    tkt_q[i] <= push_tkt_i;
                    age_q[i] <= AW'(1);
                end else begin
                    if (pop_i && (rd_q == PW'(i))) begin
                        vld_q[i] <= 1'b0;
                    end
                    if (vld_q[i] && (age_q[i] != AW'(AGE_MAX))) begin
                        age_q[i] <= age_q[i] + AW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (pop_i)  rd_q <= rd_q + PW'(1);
            if (push_i) wr_q <= wr_q + PW'(1);
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    assign head_valid_o = vld_q[rd_q];
    assign head_tkt_o   = tkt_q[rd_q];
    assign head_age_o   = age_q[rd_q];
    assign full_o       = (cnt_q == CW'(DEPTH));
    assign count_o      = cnt_q;

    // R8: the controller never writes into a full queue
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
        full_o |-> !push_i);

    // R5: a retirement always has a live head to remove
    a_r5_pop_has_head: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> head_valid_o);

    // R4: an empty queue has no head, a non-empty one always does
    a_r4_count_head: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) == !head_valid_o);

    // R2: a live head is never younger than one edge
    a_r2_head_aged: assert property (@(posedge clk) disable iff (rst)
        head_valid_o |-> (head_age_o != '0));

endmodule

// File: rtl/rgt_judge.sv
module rgt_judge
    import rgt_pkg::*;
#(
    parameter int AW     = 3,
    parameter int WIN_LO = 1,
    parameter int WIN_HI = 5
) (
    input  logic          head_valid_i,
    input  logic [AW-1:0] head_age_i,
    input  logic          gnt_i,
    output head_state_e   state_o,
    output verdict_e      verdict_o,
    output logic          pop_o,
    output logic          stray_o
);

    // State decode of the head entry.
    always_comb begin
        if (!head_valid_i) begin
            state_o = HS_IDLE;
        end else if (head_age_i < AW'(WIN_LO)) begin
            state_o = HS_EARLY;
        end else if (head_age_i >= AW'(WIN_HI)) begin
            state_o = HS_LAST;
        end else begin
            state_o = HS_OPEN;
        end
    end

    // Transition decode: pass, timeout or stray.
    always_comb begin
        verdict_o = VD_NONE;
        stray_o   = 1'b0;
        unique case (state_o)
            HS_IDLE:  stray_o = gnt_i;
            HS_EARLY: stray_o = gnt_i;
            HS_OPEN:  if (gnt_i) verdict_o = VD_PASS;
            HS_LAST:  verdict_o = gnt_i ? VD_PASS : VD_TIMEOUT;
            default:  verdict_o = VD_NONE;
        endcase
        pop_o = (verdict_o != VD_NONE);
    end

endmodule

// File: rtl/rg_ticket_monitor.sv
module rg_ticket_monitor
    import rgt_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 8,
    parameter int WIN_LO = 1,
    parameter int WIN_HI = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             gnt_i,
    output logic             pass_o,
    output logic             timeout_o,
    output logic             stray_gnt_o,
    output logic             overflow_o,
    output logic [CNT_W-1:0] ticket_o,
    output logic [CNT_W-1:0] serving_o
);

    localparam int AW  = $clog2(WIN_HI + 1);
    localparam int QCW = $clog2(DEPTH + 1);

    logic             q_full;
    logic             q_head_valid;
    logic [CNT_W-1:0] q_head_tkt;
    logic [AW-1:0]    q_head_age;
    logic [QCW-1:0]   q_count;
    logic             accept;
    logic             drop;
    logic             pop;
    logic             stray;
    head_state_e      head_state;
    verdict_e         verdict;

    logic [CNT_W-1:0] ticket_q;
    logic [CNT_W-1:0] serving_q;
    logic             pass_q;
    logic             timeout_q;
    logic             stray_q;
    logic             ovf_q;

    assign accept = req_i && !q_full;
    assign drop   = req_i && q_full;

    rgt_queue #(
        .DEPTH   (DEPTH),
        .TW      (CNT_W),
        .AW      (AW),
        .AGE_MAX (WIN_HI)
    ) u_queue (
        .clk          (clk),
        .rst          (rst),
        .push_i       (accept),
        .push_tkt_i   (ticket_q),
        .pop_i        (pop),
        .head_valid_o (q_head_valid),
        .head_tkt_o   (q_head_tkt),
        .head_age_o   (q_head_age),
        .full_o       (q_full),
        .count_o      (q_count)
    );

    rgt_judge #(
        .AW     (AW),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_judge (
        .head_valid_i (q_head_valid),
        .head_age_i   (q_head_age),
        .gnt_i        (gnt_i),
        .state_o      (head_state),
        .verdict_o    (verdict),
        .pop_o        (pop),
        .stray_o      (stray)
    );

    // State register: counters and registered verdict pulses.
    always_ff @(posedge clk) begin
        if (rst) begin
            ticket_q  <= '0;
            serving_q <= '0;
            pass_q    <= 1'b0;
            timeout_q <= 1'b0;
            stray_q   <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (accept) ticket_q  <= ticket_q + CNT_W'(1);
            if (pop)    serving_q <= serving_q + CNT_W'(1);
            pass_q    <= (verdict == VD_PASS);
            timeout_q <= (verdict == VD_TIMEOUT);
            stray_q   <= stray;
            if (drop)   ovf_q <= 1'b1;
        end
    end

    // Output process.
    always_comb begin
        pass_o      = pass_q;
        timeout_o   = timeout_q;
        stray_gnt_o = stray_q;
        overflow_o  = ovf_q;
        ticket_o    = ticket_q;
        serving_o   = serving_q;
    end

    // R1: an accepted request advances the ticket by exactly one
    a_r1_ticket_step: assert property (@(posedge clk) disable iff (rst)
        (req_i && !q_full) |=> (ticket_o == $past(ticket_o) + CNT_W'(1)));

    // R3: every verdict pulse coincides with a one-step serving advance
    a_r3_serve_step: assert property (@(posedge clk) disable iff (rst)
        (pass_o || timeout_o) |-> (serving_o == $past(serving_o) + CNT_W'(1)));

    // R4: the head of the queue is always the ticket being served
    a_r4_head_is_serving: assert property (@(posedge clk) disable iff (rst)
        q_head_valid |-> (q_head_tkt == serving_q));

    // R4: tickets in flight equal the queue occupancy
    a_r4_in_flight: assert property (@(posedge clk) disable iff (rst)
        (ticket_q - serving_q) == CNT_W'(q_count));

    // R5: the head never sits past the window in a state other than LAST
    a_r5_window_close: assert property (@(posedge clk) disable iff (rst)
        (head_state == HS_LAST) |-> pop);

    // R7: an unmatched-grant pulse follows an actual grant
    a_r7_stray_needs_grant: assert property (@(posedge clk) disable iff (rst)
        stray_gnt_o |-> $past(gnt_i));

    // R8: overflow is sticky until reset
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

endmodule

// File: tb/rg_ticket_monitor_tb.sv
module rg_ticket_monitor_tb;

    localparam int DEPTH = 4;
    localparam int CW    = 8;
    localparam int WL    = 1;
    localparam int WH    = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          req;
    logic          gnt;
    logic          pass_o;
    logic          timeout_o;
    logic          stray_gnt_o;
    logic          overflow_o;
    logic [CW-1:0] ticket_o;
    logic [CW-1:0] serving_o;

    always #4 clk = ~clk;

    rg_ticket_monitor #(
        .DEPTH (DEPTH), .CNT_W (CW), .WIN_LO (WL), .WIN_HI (WH)
    ) u_dut (
        .clk (clk), .rst (rst), .req_i (req), .gnt_i (gnt),
        .pass_o (pass_o), .timeout_o (timeout_o), .stray_gnt_o (stray_gnt_o),
        .overflow_o (overflow_o), .ticket_o (ticket_o), .serving_o (serving_o)
    );

    int checks = 0;
    int fails  = 0;

    // Expected-value model: ages of outstanding requests, oldest first.
    int mq_age [DEPTH];
    int mq_n;
    int m_tkt;
    int m_srv;
    bit m_ovf;
    bit e_pass;
    bit e_to;
    bit e_stray;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mq_n = 0; m_tkt = 0; m_srv = 0; m_ovf = 0;
        e_pass = 0; e_to = 0; e_stray = 0;
        for (int i = 0; i < DEPTH; i++) mq_age[i] = 0;
    endtask

    task automatic model_edge(input bit r, input bit g);
        bit full;
        bit credit;
        bit popped;
        full   = (mq_n == DEPTH);
        credit = (mq_n > 0) && g && (mq_age[0] >= WL) && (mq_age[0] <= WH);
        e_pass = credit;
        e_to   = !credit && (mq_n > 0) && (mq_age[0] >= WH);
        e_stray = g && !credit;
        popped = e_pass || e_to;
        if (popped) begin
            for (int i = 0; i < DEPTH - 1; i++) mq_age[i] = mq_age[i+1];
            mq_n--;
            m_srv = (m_srv + 1) % (1 << CW);
        end
        for (int i = 0; i < mq_n; i++) if (mq_age[i] < WH) mq_age[i]++;
        if (r) begin
            if (full) m_ovf = 1;
            else begin
                mq_age[mq_n] = 1;
                mq_n++;
                m_tkt = (m_tkt + 1) % (1 << CW);
            end
        end
    endtask

    task automatic compare();
        chk("R2 pass_o",        int'(pass_o),      int'(e_pass));
        chk("R5 timeout_o",     int'(timeout_o),   int'(e_to));
        chk("R7 stray_gnt_o",   int'(stray_gnt_o), int'(e_stray));
        chk("R8 overflow_o",    int'(overflow_o),  int'(m_ovf));
        chk("R1 ticket_o",      int'(ticket_o),    m_tkt);
        chk("R3 serving_o",     int'(serving_o),   m_srv);
    endtask

    // Called at a falling edge: drive, let one rising edge sample, check at next fall.
    task automatic step(input bit r, input bit g);
        req = r;
        gnt = g;
        @(posedge clk);
        model_edge(r, g);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1; req = 1'b0; gnt = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R9: everything cleared
        chk("R9 reset ticket_o",  int'(ticket_o),  0);
        chk("R9 reset serving_o", int'(serving_o), 0);
        chk("R9 reset pulses",    int'({pass_o, timeout_o, stray_gnt_o}), 0);
        chk("R9 reset overflow",  int'(overflow_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual cycles=200000 expected fewer");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; req = 1'b0; gnt = 1'b0;
        @(negedge clk);
        do_reset();

        // R6: grant on the sampling edge is not credited to the new request
        step(1'b1, 1'b1);
        chk("R6 same-edge grant not credited", int'(pass_o), 0);
        chk("R6 same-edge grant is stray",     int'(stray_gnt_o), 1);
        for (int k = 0; k < WH; k++) step(1'b0, 1'b0);
        chk("R6 request then times out", int'(timeout_o), 1);

        // R4: three pending requests, one grant credits only the head
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R4 single grant one pass", int'(pass_o), 1);
        chk("R4 two tickets still outstanding", int'(ticket_o - serving_o), 2);
        step(1'b0, 1'b0);
        chk("R4 others keep waiting", int'(pass_o), 0);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b0);
        chk("R4 late requests timed out", int'(ticket_o - serving_o), 0);

        // Exhaustive sweep over every 5-cycle request/grant pattern.
        for (int p = 0; p < 1024; p++) begin
            for (int c = 0; c < 5; c++) step(p[2*c], p[2*c+1]);
            for (int c = 0; c < 8; c++) step(1'b0, 1'b0);
        end

        // R9: reset in the middle of activity
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        do_reset();

        // Dense requests, rare grants: repeated full-queue and late-grant cases.
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4]);
        end
        chk("R8 overflow reached in dense run", int'(overflow_o), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule